// File: doc/BRIEF.md
# Collapsing Age-Ordered Issue Queue

This block is a small instruction issue queue for an out-of-order core. It takes in renamed instructions and holds them until both source operands are known to be available. It then hands up to N of them per cycle to N identical execution pipes. Each entry keeps an operation class, a destination tag, two source tags and a ready flag for each source. A result-tag bus of N lanes is compared against every waiting source on every cycle. A match marks that source available. This is the wake-up step.

The storage compacts itself. When entries leave, the survivors slide toward slot 0 without changing their relative order, so the slot index is the age of the instruction. Selection scans from slot 0 upward and grants the first eligible entries. As a result the oldest ready instructions always win the issue slots. New instructions go in directly above the surviving entries. A flush input discards the whole queue in one cycle.

Insertion uses a valid/ready stream. The producer raises one `ins_vld` bit per lane, and lane 0 is treated as older than lane 1. `ins_rdy` is high only when the whole offered group fits. The group is taken on a rising edge where `ins_rdy` is high, and it is never taken in part. While `ins_rdy` is low the producer may hold its offer or change it. Issue is also a valid/ready stream, with one `iss_vld` bit per slot and a single `iss_rdy` shared by all slots. A presented instruction leaves the queue on the edge where `iss_rdy` is high. While `iss_rdy` is low it stays presented.

Top module: `iq_collapse`

## Requirements
- R1: After reset the queue is empty. `iss_vld` is all zero, and `ins_rdy` is high for any offer of N or fewer instructions while flush is low.
- R2: `ins_rdy` is high exactly when flush is low and the number of set `ins_vld` bits is no more than DEPTH minus the occupancy at the start of the cycle. When `ins_rdy` is low, nothing offered is stored.
- R3: Accepted instructions keep arrival order. An earlier cycle is older than a later one, and within one cycle a lower lane is older than a higher lane.
- R4: An entry is eligible when both of its source ready flags are set. A flag is set at insertion either from the matching `ins_s1_rdy`/`ins_s2_rdy` bit or by a tag match on a valid result-bus lane in the same cycle. A flag not set at insertion is set later by a match on a valid result-bus lane in any cycle.
- R5: Issue slot j, counting from 0, presents the j-th oldest eligible entry. Occupied slots are contiguous from slot 0, and at most N are presented per cycle.
- R6: An entry leaves on the edge where its slot has `iss_vld` and `iss_rdy` both high. With `iss_rdy` low, nothing leaves and the presented entries remain eligible.
- R7: Wake-up and insertion are registered. An instruction cannot be presented in the cycle it is offered. A result broadcast in cycle t makes a waiting entry eligible no earlier than cycle t+1.
- R8: After removal, the surviving entries move down with their order kept. Occupancy always equals the number of valid slots, and it changes by the number accepted minus the number issued.
- R9: Flush forces `ins_rdy` low and empties the queue at the next edge, whatever is being issued or broadcast in that cycle.
- R10: A broadcast tag that matches no waiting source changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard all entries at the next edge |
| ins_vld | input | N | Offered instruction per lane; lane 0 is oldest |
| ins_rdy | output | 1 | Whole offered group is accepted this cycle |
| ins_op | input | N*OP_W | Operation class per lane |
| ins_dst | input | N*TAG_W | Destination tag per lane |
| ins_s1 | input | N*TAG_W | First source tag per lane |
| ins_s1_rdy | input | N | First source already available, per lane |
| ins_s2 | input | N*TAG_W | Second source tag per lane |
| ins_s2_rdy | input | N | Second source already available, per lane |
| res_vld | input | N | Valid flag per result-bus lane |
| res_tag | input | N*TAG_W | Result tag per result-bus lane |
| iss_vld | output | N | Issue slot holds an instruction |
| iss_rdy | input | 1 | Execution side takes all presented slots |
| iss_op | output | N*OP_W | Operation class per issue slot |
| iss_dst | output | N*TAG_W | Destination tag per issue slot |

## Verification
The checker relies on a few properties of the surrounding logic. `iss_rdy` acts on all presented slots together. The producer may change or withdraw its offer while `ins_rdy` is low, and this must not disturb occupancy accounting. No input carries unknown values after reset. Ready flags only ever rise while an entry is held, and the hold property depends on that. The stimulus drives every input with defined values on falling edges. It withdraws and reshapes offers at random while back-pressured, and it puts flush, stalled issue and matching or non-matching broadcasts in the same cycles. The source and result tags come from a narrow range, so wake-ups and simultaneous insert-and-wake cases occur often.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned IQ_DEF_LANES = 2;
  localparam int unsigned IQ_DEF_DEPTH = 8;
  localparam int unsigned IQ_DEF_TAG_W = 4;
  localparam int unsigned IQ_DEF_OP_W  = 3;

  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/iq_tag_match.sv
module iq_tag_match #(
  parameter int N     = 2,
  parameter int TAG_W = 4
) (
  input  logic [TAG_W-1:0]   tag,
  input  logic [N-1:0]       bus_vld,
  input  logic [N*TAG_W-1:0] bus_tag,
  output logic               hit
);
  logic [N-1:0] lane_hit;

  for (genvar k = 0; k < N; k++) begin : g_lane
    assign lane_hit[k] = bus_vld[k] && (bus_tag[k*TAG_W +: TAG_W] == tag);
  end

  assign hit = |lane_hit;
endmodule

// File: rtl/iq_oldest_pick.sv
module iq_oldest_pick #(
  parameter int DEPTH = 8,
  parameter int N     = 2,
  localparam int IDX_W = iq_pkg::width_for(DEPTH)
) (
  input  logic [DEPTH-1:0]   elig,
  output logic [DEPTH-1:0]   gnt,
  output logic [N-1:0]       slot_vld,
  output logic [N*IDX_W-1:0] slot_idx
);
  always_comb begin
    int taken;
    taken    = 0;
    gnt      = '0;
    slot_vld = '0;
    slot_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (elig[i] && taken < N) begin
        gnt[i]                          = 1'b1;
        slot_vld[taken]                 = 1'b1;
        slot_idx[taken*IDX_W +: IDX_W]  = IDX_W'(i);
        taken                           = taken + 1;
      end
    end
  end
endmodule

// File: rtl/iq_pack_map.sv
module iq_pack_map #(
  parameter int DEPTH = 8,
  localparam int IDX_W = iq_pkg::width_for(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]       keep,
  output logic [DEPTH*IDX_W-1:0] rank,
  output logic [CNT_W-1:0]       nkeep
);
  always_comb begin
    logic [CNT_W-1:0] run;
    run  = '0;
    rank = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rank[i*IDX_W +: IDX_W] = run[IDX_W-1:0];
      if (keep[i]) run = run + CNT_W'(1);
    end
    nkeep = run;
  end
endmodule

// File: rtl/iq_collapse.sv
module iq_collapse #(
  parameter int N     = iq_pkg::IQ_DEF_LANES,
  parameter int DEPTH = iq_pkg::IQ_DEF_DEPTH,
  parameter int TAG_W = iq_pkg::IQ_DEF_TAG_W,
  parameter int OP_W  = iq_pkg::IQ_DEF_OP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [N-1:0]       ins_vld,
  output logic               ins_rdy,
  input  logic [N*OP_W-1:0]  ins_op,
  input  logic [N*TAG_W-1:0] ins_dst,
  input  logic [N*TAG_W-1:0] ins_s1,
  input  logic [N-1:0]       ins_s1_rdy,
  input  logic [N*TAG_W-1:0] ins_s2,
  input  logic [N-1:0]       ins_s2_rdy,
  input  logic [N-1:0]       res_vld,
  input  logic [N*TAG_W-1:0] res_tag,
  output logic [N-1:0]       iss_vld,
  input  logic               iss_rdy,
  output logic [N*OP_W-1:0]  iss_op,
  output logic [N*TAG_W-1:0] iss_dst
);
  localparam int IDX_W = iq_pkg::width_for(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // stored entries; slot 0 is the oldest
  logic [DEPTH-1:0] q_vld, q_r1, q_r2;
  logic [OP_W-1:0]  q_op  [DEPTH];
  logic [TAG_W-1:0] q_dst [DEPTH];
  logic [TAG_W-1:0] q_s1  [DEPTH];
  logic [TAG_W-1:0] q_s2  [DEPTH];
  logic [CNT_W-1:0] cnt;

  logic [DEPTH-1:0] n_vld, n_r1, n_r2;
  logic [OP_W-1:0]  n_op  [DEPTH];
  logic [TAG_W-1:0] n_dst [DEPTH];
  logic [TAG_W-1:0] n_s1  [DEPTH];
  logic [TAG_W-1:0] n_s2  [DEPTH];
  logic [CNT_W-1:0] n_cnt;

  // wake-up: every stored source against the result bus
  logic [DEPTH-1:0] eh1, eh2;
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent_wake
    iq_tag_match #(.N(N), .TAG_W(TAG_W)) u_m1 (
      .tag(q_s1[i]), .bus_vld(res_vld), .bus_tag(res_tag), .hit(eh1[i]));
    iq_tag_match #(.N(N), .TAG_W(TAG_W)) u_m2 (
      .tag(q_s2[i]), .bus_vld(res_vld), .bus_tag(res_tag), .hit(eh2[i]));
  end

  // wake-up of incoming lanes in their insertion cycle
  logic [N-1:0] lh1, lh2;
  for (genvar k = 0; k < N; k++) begin : g_lane_wake
    iq_tag_match #(.N(N), .TAG_W(TAG_W)) u_l1 (
      .tag(ins_s1[k*TAG_W +: TAG_W]), .bus_vld(res_vld), .bus_tag(res_tag), .hit(lh1[k]));
    iq_tag_match #(.N(N), .TAG_W(TAG_W)) u_l2 (
      .tag(ins_s2[k*TAG_W +: TAG_W]), .bus_vld(res_vld), .bus_tag(res_tag), .hit(lh2[k]));
  end

  // selection: oldest eligible entries first
  logic [DEPTH-1:0]   elig, gnt;
  logic [N*IDX_W-1:0] slot_idx;
  assign elig = q_vld & q_r1 & q_r2;

  iq_oldest_pick #(.DEPTH(DEPTH), .N(N)) u_pick (
    .elig(elig), .gnt(gnt), .slot_vld(iss_vld), .slot_idx(slot_idx));

  for (genvar j = 0; j < N; j++) begin : g_slot
    logic [IDX_W-1:0] sidx;
    assign sidx = slot_idx[j*IDX_W +: IDX_W];
    assign iss_op[j*OP_W +: OP_W]    = q_op[sidx];
    assign iss_dst[j*TAG_W +: TAG_W] = q_dst[sidx];
  end

  // compaction map of survivors
  logic [DEPTH-1:0]       keep;
  logic [DEPTH*IDX_W-1:0] rank;
  logic [CNT_W-1:0]       nkeep;
  assign keep = q_vld & ~(gnt & {DEPTH{iss_rdy}});

  iq_pack_map #(.DEPTH(DEPTH)) u_pack (.keep(keep), .rank(rank), .nkeep(nkeep));

  // offered group size and lane placement offsets
  logic [CNT_W-1:0] offer_n;
  logic [CNT_W-1:0] lane_off [N];
  always_comb begin
    offer_n = '0;
    for (int k = 0; k < N; k++) begin
      lane_off[k] = offer_n;
      if (ins_vld[k]) offer_n = offer_n + CNT_W'(1);
    end
  end

  logic [CNT_W-1:0] free_n;
  assign free_n  = CNT_W'(DEPTH) - cnt;
  assign ins_rdy = !flush && (offer_n <= free_n);

  always_comb begin
    logic [IDX_W-1:0] p;
    p     = '0;
    n_vld = '0;
    n_r1  = '0;
    n_r2  = '0;
    for (int d = 0; d < DEPTH; d++) begin
      n_op[d]  = '0;
      n_dst[d] = '0;
      n_s1[d]  = '0;
      n_s2[d]  = '0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (keep[i]) begin
        p        = rank[i*IDX_W +: IDX_W];
        n_vld[p] = 1'b1;
        n_op[p]  = q_op[i];
        n_dst[p] = q_dst[i];
        n_s1[p]  = q_s1[i];
        n_s2[p]  = q_s2[i];
        n_r1[p]  = q_r1[i] | eh1[i];
        n_r2[p]  = q_r2[i] | eh2[i];
      end
    end
    if (ins_rdy) begin
      for (int k = 0; k < N; k++) begin
        if (ins_vld[k]) begin
          p        = IDX_W'(nkeep + lane_off[k]);
          n_vld[p] = 1'b1;
          n_op[p]  = ins_op[k*OP_W +: OP_W];
          n_dst[p] = ins_dst[k*TAG_W +: TAG_W];
          n_s1[p]  = ins_s1[k*TAG_W +: TAG_W];
          n_s2[p]  = ins_s2[k*TAG_W +: TAG_W];
          n_r1[p]  = ins_s1_rdy[k] | lh1[k];
          n_r2[p]  = ins_s2_rdy[k] | lh2[k];
        end
      end
    end
    if (flush) n_vld = '0;
    n_cnt = flush ? '0 : (nkeep + (ins_rdy ? offer_n : '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      q_vld <= '0;
      q_r1  <= '0;
      q_r2  <= '0;
      for (int d = 0; d < DEPTH; d++) begin
        q_op[d]  <= '0;
        q_dst[d] <= '0;
        q_s1[d]  <= '0;
        q_s2[d]  <= '0;
      end
    end else begin
      cnt   <= n_cnt;
      q_vld <= n_vld;
      q_r1  <= n_r1;
      q_r2  <= n_r2;
      for (int d = 0; d < DEPTH; d++) begin
        q_op[d]  <= n_op[d];
        q_dst[d] <= n_dst[d];
        q_s1[d]  <= n_s1[d];
        q_s2[d]  <= n_s2[d];
      end
    end
  end
endmodule

// File: rtl/iq_collapse_chk.sv
module iq_collapse_chk #(
  parameter int N     = 2,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic [N-1:0]     ins_vld,
  input logic             ins_rdy,
  input logic [N-1:0]     iss_vld,
  input logic             iss_rdy,
  input logic [CNT_W-1:0] occ,
  input logic [DEPTH-1:0] vld_vec
);
  int acc_n, fire_n;
  always_comb begin
    acc_n  = ins_rdy ? $countones(ins_vld) : 0;
    fire_n = iss_rdy ? $countones(iss_vld) : 0;
  end

  p_empty_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> (iss_vld == '0 && ins_rdy == !flush));

  p_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_rdy |-> (int'(occ) + $countones(ins_vld) <= DEPTH));

  p_slots_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld & (iss_vld + N'(1))) == '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !iss_rdy && iss_vld[0]) |=> iss_vld[0]);

  p_occ_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_vec) == int'(occ));

  p_packed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_vec & (vld_vec + DEPTH'(1))) == '0);

  p_occ_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> int'(occ) == $past(int'(occ)) + $past(acc_n) - $past(fire_n));

  p_flush_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !ins_rdy);

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0 && iss_vld == '0));
endmodule

bind iq_collapse iq_collapse_chk #(.N(N), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .ins_vld(ins_vld), .ins_rdy(ins_rdy),
  .iss_vld(iss_vld), .iss_rdy(iss_rdy), .occ(cnt), .vld_vec(q_vld));

// File: tb/test_iq_collapse.sv
module test_iq_collapse;
  localparam int CLK_P = 10;
  localparam int N     = 2;
  localparam int DEPTH = 8;
  localparam int TAG_W = 4;
  localparam int OP_W  = 3;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, iss_rdy = 1'b0;
  logic [N-1:0]       ins_vld = '0, ins_s1_rdy = '0, ins_s2_rdy = '0, res_vld = '0;
  logic [N*OP_W-1:0]  ins_op = '0;
  logic [N*TAG_W-1:0] ins_dst = '0, ins_s1 = '0, ins_s2 = '0, res_tag = '0;
  logic               ins_rdy;
  logic [N-1:0]       iss_vld;
  logic [N*OP_W-1:0]  iss_op;
  logic [N*TAG_W-1:0] iss_dst;

  iq_collapse #(.N(N), .DEPTH(DEPTH), .TAG_W(TAG_W), .OP_W(OP_W)) i_iq_collapse (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ins_vld(ins_vld), .ins_rdy(ins_rdy),
    .ins_op(ins_op), .ins_dst(ins_dst), .ins_s1(ins_s1), .ins_s1_rdy(ins_s1_rdy),
    .ins_s2(ins_s2), .ins_s2_rdy(ins_s2_rdy), .res_vld(res_vld), .res_tag(res_tag),
    .iss_vld(iss_vld), .iss_rdy(iss_rdy), .iss_op(iss_op), .iss_dst(iss_dst));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, m_cnt = 0, id = 0;
  bit done = 1'b0, removed_last = 1'b0;
  int m_id [DEPTH];
  logic [TAG_W-1:0] m_s1 [DEPTH], m_s2 [DEPTH];
  bit m_r1 [DEPTH], m_r2 [DEPTH];
  logic [31:0] seed = 32'h1d2c3b4a;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit bus_hit(input logic [TAG_W-1:0] t);
    for (int k = 0; k < N; k++)
      if (res_vld[k] && res_tag[k*TAG_W +: TAG_W] == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic idle_in();
    flush = 1'b0; ins_vld = '0; res_vld = '0; ins_s1_rdy = '0; ins_s2_rdy = '0;
  endtask

  // set lane k to a fresh instruction; {op,dst} carries a 7-bit identity
  task automatic lane(input int k, input logic [TAG_W-1:0] s1, input bit r1,
                      input logic [TAG_W-1:0] s2, input bit r2);
    ins_vld[k] = 1'b1;
    {ins_op[k*OP_W +: OP_W], ins_dst[k*TAG_W +: TAG_W]} = 7'(id);
    id = (id + 1) % 128;
    ins_s1[k*TAG_W +: TAG_W] = s1; ins_s1_rdy[k] = r1;
    ins_s2[k*TAG_W +: TAG_W] = s2; ins_s2_rdy[k] = r2;
  endtask

  // called at a falling edge with inputs set; compares, updates model, advances one cycle
  task automatic step();
    int e_idx [N];
    int e_n, offered, j;
    bit e_rdy;
    bit fired [DEPTH];
    #1;
    e_n = 0;
    for (int i = 0; i < m_cnt; i++) begin
      fired[i] = 1'b0;
      if (m_r1[i] && m_r2[i] && e_n < N) begin e_idx[e_n] = i; e_n++; end
    end
    offered = $countones(ins_vld);
    e_rdy = !flush && (DEPTH - m_cnt) >= offered;
    check(flush ? "R9" : "R2", "ins_rdy", int'(ins_rdy), int'(e_rdy));
    for (int s = 0; s < N; s++) begin
      check("R5", "iss_vld slot", int'(iss_vld[s]), int'(s < e_n));
      if (s < e_n && iss_vld[s])
        check(removed_last ? "R8" : "R3", "issued identity",
              int'({iss_op[s*OP_W +: OP_W], iss_dst[s*TAG_W +: TAG_W]}), m_id[e_idx[s]]);
    end
    removed_last = 1'b0;
    if (flush) m_cnt = 0;
    else begin
      if (iss_rdy) for (int s = 0; s < e_n; s++) begin fired[e_idx[s]] = 1'b1; removed_last = 1'b1; end
      j = 0;
      for (int i = 0; i < m_cnt; i++) begin
        if (!fired[i]) begin
          m_id[j] = m_id[i]; m_s1[j] = m_s1[i]; m_s2[j] = m_s2[i];
          m_r1[j] = m_r1[i] | bus_hit(m_s1[i]);
          m_r2[j] = m_r2[i] | bus_hit(m_s2[i]);
          j++;
        end
      end
      m_cnt = j;
      if (e_rdy) for (int k = 0; k < N; k++) begin
        if (ins_vld[k]) begin
          m_id[m_cnt] = int'({ins_op[k*OP_W +: OP_W], ins_dst[k*TAG_W +: TAG_W]});
          m_s1[m_cnt] = ins_s1[k*TAG_W +: TAG_W];
          m_s2[m_cnt] = ins_s2[k*TAG_W +: TAG_W];
          m_r1[m_cnt] = ins_s1_rdy[k] | bus_hit(ins_s1[k*TAG_W +: TAG_W]);
          m_r2[m_cnt] = ins_s2_rdy[k] | bus_hit(ins_s2[k*TAG_W +: TAG_W]);
          m_cnt++;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, full offer accepted
    lane(0, 4'd0, 1'b1, 4'd0, 1'b1); lane(1, 4'd0, 1'b1, 4'd0, 1'b1);
    #1;
    check("R1", "iss_vld after reset", int'(iss_vld), 0);
    check("R1", "ins_rdy when empty", int'(ins_rdy), 1);
    // R7: insertion cycle shows nothing, next cycle presents both
    check("R7", "no issue in insertion cycle", int'(iss_vld), 0);
    step();
    check("R7", "ready entries presented next cycle", int'(iss_vld), 3);
    idle_in(); iss_rdy = 1'b1; step();

    // R4/R10: wait on tag 5, unrelated tag 9 does nothing, tag 5 wakes
    lane(0, 4'd5, 1'b0, 4'd1, 1'b1); step();
    idle_in(); res_vld[0] = 1'b1; res_tag[3:0] = 4'd9; step();
    check("R10", "unmatched broadcast leaves entry waiting", int'(iss_vld), 0);
    res_tag[3:0] = 4'd5; #1;
    check("R7", "no issue in wake cycle", int'(iss_vld), 0);
    step();
    check("R4", "woken entry eligible", int'(iss_vld), 1);
    idle_in(); step();

    // R4: broadcast in the insertion cycle on lane 1 of the bus
    lane(0, 4'd6, 1'b0, 4'd6, 1'b0); res_vld[1] = 1'b1; res_tag[7:4] = 4'd6; step();
    check("R4", "insert-cycle wake", int'(iss_vld), 1);
    idle_in(); step();

    // R6/R3: stall issue, three ready entries over two cycles
    iss_rdy = 1'b0;
    lane(0, 4'd0, 1'b1, 4'd0, 1'b1); lane(1, 4'd0, 1'b1, 4'd0, 1'b1); step();
    idle_in(); lane(0, 4'd0, 1'b1, 4'd0, 1'b1); step();
    idle_in(); step();
    check("R6", "stalled entries still presented", int'(iss_vld), 3);
    iss_rdy = 1'b1; step();
    check("R3", "youngest follows after oldest pair", int'(iss_vld), 1);
    step();

    // R2: fill with waiting entries, then one more is refused
    iss_rdy = 1'b0;
    for (int c = 0; c < DEPTH / N; c++) begin
      idle_in(); lane(0, 4'd3, 1'b0, 4'd3, 1'b0); lane(1, 4'd3, 1'b0, 4'd3, 1'b0); step();
    end
    idle_in(); lane(0, 4'd0, 1'b1, 4'd0, 1'b1); #1;
    check("R2", "full queue refuses offer", int'(ins_rdy), 0);
    step();
    idle_in(); step();
    check("R2", "refused instruction not stored", int'(iss_vld), 0);

    // R9: flush with a matching broadcast and issue enabled
    flush = 1'b1; iss_rdy = 1'b1; res_vld = 2'b01; res_tag[3:0] = 4'd3; #1;
    check("R9", "ins_rdy low during flush", int'(ins_rdy), 0);
    step();
    idle_in(); #1;
    check("R9", "queue empty after flush", int'(iss_vld), 0);
    lane(0, 4'd0, 1'b1, 4'd0, 1'b1); lane(1, 4'd0, 1'b1, 4'd0, 1'b1); #1;
    check("R9", "full room after flush", int'(ins_rdy), 1);
    step(); idle_in(); step(); step();

    // sweep: random offers, stalls, broadcasts and flushes against the model
    for (int cyc = 0; cyc < 6000; cyc++) begin
      logic [31:0] r;
      idle_in();
      r = rnd();
      for (int k = 0; k < N; k++)
        if (r[k]) lane(k, TAG_W'(r[8+4*k +: 2]), r[16+k], TAG_W'(r[10+4*k +: 2]), r[18+k]);
      iss_rdy = (r[21:20] != 2'b00);
      r = rnd();
      res_vld = r[1:0];
      res_tag = {TAG_W'(r[4:2]), TAG_W'(r[7:5])};
      flush = (r[15:10] == 6'd0);
      step();
    end

    done = 1'b1;
    finish_run();
  end
endmodule